// File: doc/BRIEF.md
# Unstoppable Countdown Watchdog

The block is a watchdog timer. Software reaches it through five 16-bit registers on a simple write-strobe bus with a combinational read path. The block runs on the system clock `clk`. A one-cycle enable `tick_en` marks each edge of a 32 kHz low-frequency reference. A prescaler divides those ticks by `TICK_DIV` (16384 by default) to make half-second steps. The countdown starts from `WT+1` steps. It begins when the enable bit is first set, and from then on only a reset can stop it. A service write pair of 0x5555 followed by 0xAAAA reloads the count.

When the count runs out, the block raises a timeout event that lasts one clock. Depending on a control bit, the event drives either an internal reset request or an active-low external reset output. It also sets a cause flag that survives a system reset and is cleared only by power-on reset or by a software reset request. An optional pre-timeout interrupt can fire a programmable number of half-second steps before expiry. Software can also drive both reset outputs directly through active-low control bits.

Register offsets are 0x0 (control), 0x2 (service), 0x4 (cause), 0x6 (interrupt control) and 0x8 (power-down disable). The service register always reads 0.

Top module: `lf_watchdog`

## Requirements
- R1: After power-on reset the control register reads 0x0030 and the interrupt control register reads 0x0000. The cause register reads 0x0000 and the power-down register reads 0x0001. `int_rst_req` is 0, `ext_rst_n` is 1 and `irq` is 0.
- R2: Control bits 15:8 hold WT. With `tick_en` high every cycle, the first timeout event comes exactly `TICK_DIV*(WT+1)` clocks after the write edge that sets enable. The event lasts one clock, and the next one follows a further `TICK_DIV*(WT+1)` clocks later.
- R3: Control bit 2 is the enable. Writing 0 to it once it is set has no effect: it still reads 1, and the countdown is neither stopped nor reloaded.
- R4: A write of 0xAAAA to offset 0x2 reloads the count (same timing as R2, measured from that write edge) only when the previous service write was 0x5555. 0xAAAA alone, 0xAAAA before 0x5555, or another value between the two does not reload. When the reload lands on the expiry edge, the reload wins and no timeout event occurs.
- R5: Control bit 3 picks the expiry action. When it is 0, the event shows as `int_rst_req`=1 with `ext_rst_n` staying 1. When it is 1, the event shows as `ext_rst_n`=0 with `int_rst_req` staying 0.
- R6: Control bit 4 is an active-low software reset. While it holds 0, `int_rst_req` is 1; writing 1 releases it.
- R7: Control bit 5 is an active-low external reset control. While it holds 0, `ext_rst_n` is 0 and `int_rst_req` stays 0.
- R8: While control bit 0 is 1 and `lp_mode` is high, both the prescaler and the count freeze, which delays expiry by exactly the frozen cycles. With bit 0 at 0, `lp_mode` has no effect. Only the first control write after reset can set bit 0.
- R9: In the interrupt control register, bit 14 is set on the step that leaves the count equal to bits 7:0 (when those bits are nonzero), i.e. `TICK_DIV*(WT+1-P)` clocks after enable. Bit 15 gates `irq`. Writing 1 to bit 14 clears it, and writing 0 leaves it unchanged.
- R10: Bit 1 of the cause register becomes 1 after a timeout event. It keeps that value through `rst_n` and is cleared by `por_n` or by asserting the software reset (R6).
- R11: Bit 0 of the power-down register resets to 1. A write with bit 0 clear sets it to 0, and it cannot be set to 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, keeps the timeout cause |
| tick_en | input | 1 | One-cycle strobe per 32 kHz reference period |
| lp_mode | input | 1 | Low-power mode indication |
| addr | input | AW (4) | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| int_rst_req | output | 1 | Internal reset request, active high |
| ext_rst_n | output | 1 | External reset, active low |
| irq | output | 1 | Pre-timeout interrupt |

## Verification
The countdown expiry and the completion of a service sequence can land on the same clock edge. The bench provokes this by counting clocks from the enable write and timing the 0xAAAA write so that it commits on exactly the edge where the count would run out. It judges the outcome in two ways. First, `int_rst_req` must be low in the sample right after that edge. Second, the next event must arrive one full period later, which shows the count was reloaded rather than allowed to expire.

// File: rtl/lf_watchdog.sv
module lf_watchdog #(
  parameter int TICK_DIV = 16384,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          lp_mode,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  output logic          int_rst_req,
  output logic          ext_rst_n,
  output logic          irq
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = 9;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_SVC  = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_ICR  = AW'(6);
  localparam logic [AW-1:0] A_MISC = AW'(8);
  localparam logic [15:0] KEY_A = 16'h5555;
  localparam logic [15:0] KEY_B = 16'hAAAA;

  logic [7:0]    wt, pre;
  logic          ext_n, sw_n, act, en, zst, zst_lock;
  logic          armed, tout_q, tout_cause, ie, wtis, pd;
  logic [CW-1:0] cnt;
  logic [PW-1:0] presc;

  wire sys_n   = por_n & rst_n;
  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_svc  = wr_en && addr == A_SVC;
  wire wr_icr  = wr_en && addr == A_ICR;
  wire wr_misc = wr_en && addr == A_MISC;

  wire [7:0]    wt_src    = wr_ctrl ? wdata[15:8] : wt;
  wire [CW-1:0] load      = CW'(wt_src) + CW'(1);
  wire          svc_ok    = wr_svc && armed && wdata == KEY_B;
  wire          start     = wr_ctrl && !en && wdata[2];
  wire          reload    = start || svc_ok;
  wire          run       = en && !(zst && lp_mode);
  wire          half_tick = run && tick_en && presc == PRE_LAST && !reload;
  wire          expire    = half_tick && cnt == CW'(1);
  wire          pre_hit   = half_tick && pre != 8'd0 && cnt == CW'(pre) + CW'(1);

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      wt <= '0; ext_n <= 1'b1; sw_n <= 1'b1; act <= 1'b0;
      en <= 1'b0; zst <= 1'b0; zst_lock <= 1'b0;
    end else if (wr_ctrl) begin
      wt       <= wdata[15:8];
      ext_n    <= wdata[5];
      sw_n     <= wdata[4];
      act      <= wdata[3];
      en       <= en | wdata[2];
      zst_lock <= 1'b1;
      if (!zst_lock) zst <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      cnt <= '0; presc <= '0; tout_q <= 1'b0; armed <= 1'b0;
    end else begin
      tout_q <= expire;
      if (wr_svc) armed <= (wdata == KEY_A);
      if (reload) begin
        cnt   <= load;
        presc <= '0;
      end else if (run && tick_en) begin
        presc <= (presc == PRE_LAST) ? '0 : presc + PW'(1);
        if (half_tick) cnt <= expire ? load : cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n) begin
      ie <= 1'b0; wtis <= 1'b0; pre <= '0; pd <= 1'b1;
    end else begin
      if (wr_icr) begin
        ie  <= wdata[15];
        pre <= wdata[7:0];
      end
      wtis <= pre_hit || (wtis && !(wr_icr && wdata[14]));
      if (wr_misc && !wdata[0]) pd <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      tout_cause <= 1'b0;
    else if (!sw_n)  tout_cause <= 1'b0;
    else if (tout_q) tout_cause <= 1'b1;
  end

  assign int_rst_req = (tout_q && !act) || !sw_n;
  assign ext_rst_n   = !(tout_q && act) && ext_n;
  assign irq         = ie && wtis;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {wt, 2'b00, ext_n, sw_n, act, en, 1'b0, zst};
      A_STAT:  rdata = {14'd0, tout_cause, 1'b0};
      A_ICR:   rdata = {ie, wtis, 6'd0, pre};
      A_MISC:  rdata = {15'd0, pd};
      default: rdata = 16'd0;
    endcase
  end
endmodule

module lf_watchdog_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          en,
  input logic [CW-1:0] cnt,
  input logic          tout_q,
  input logic          zst,
  input logic          zst_lock,
  input logic          lp_mode,
  input logic          reload,
  input logic          wtis,
  input logic          half_tick,
  input logic          pd,
  input logic          tout_cause
);
  logic sys_n;
  assign sys_n = por_n & rst_n;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!sys_n) en |=> en); // R3
  AST_IDLE_CNT: assert property (@(posedge clk) disable iff (!sys_n) !en |-> cnt == '0); // R3
  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!sys_n) en |-> cnt != '0); // R2
  AST_TOUT_PULSE: assert property (@(posedge clk) disable iff (!sys_n) tout_q |=> !tout_q); // R2
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!sys_n)
    (en && zst && lp_mode && !reload) |=> $stable(cnt)); // R8
  AST_ZST_ONCE: assert property (@(posedge clk) disable iff (!sys_n) zst_lock |=> $stable(zst)); // R8
  AST_PRE_ON_TICK: assert property (@(posedge clk) disable iff (!sys_n) $rose(wtis) |-> $past(half_tick)); // R9
  AST_CAUSE_SRC: assert property (@(posedge clk) disable iff (!por_n) $rose(tout_cause) |-> $past(tout_q)); // R10
  AST_PD_ONEWAY: assert property (@(posedge clk) disable iff (!sys_n) !pd |=> !pd); // R11
endmodule

bind lf_watchdog lf_watchdog_chk #(.CW(9)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .en(en), .cnt(cnt), .tout_q(tout_q),
  .zst(zst), .zst_lock(zst_lock), .lp_mode(lp_mode), .reload(reload),
  .wtis(wtis), .half_tick(half_tick), .pd(pd), .tout_cause(tout_cause)
);

// File: tb/lf_watchdog_test.sv
`timescale 1ns/1ps
module lf_watchdog_test;
  localparam int DIV = 4;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, tick_en = 1'b1, lp_mode = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic int_rst_req, ext_rst_n, irq;
  int cyc = 0, checks = 0, errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lf_watchdog #(.TICK_DIV(DIV), .AW(4)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en), .lp_mode(lp_mode),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .int_rst_req(int_rst_req), .ext_rst_n(ext_rst_n), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk); addr = a; #1; d = int'(rdata);
  endtask

  task automatic full_reset();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0; lp_mode = 1'b0;
    @(negedge clk); @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  function automatic bit seen(input int kind);
    if (kind == 0) return int_rst_req;
    if (kind == 1) return !ext_rst_n;
    return irq;
  endfunction

  task automatic wait_ev(input int kind, input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (seen(kind)) begin at = cyc; break; end
    end
  endtask

  task automatic until_cyc(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  initial begin
    int d, t0, t1, at, at2;
    full_reset();
    // R1 reset state
    check("R1 int_rst_req", int_rst_req, 0);
    check("R1 ext_rst_n", ext_rst_n, 1);
    check("R1 irq", irq, 0);
    rd(4'h0, d); check("R1 ctrl", d, 16'h0030);
    rd(4'h6, d); check("R1 icr", d, 0);
    rd(4'h8, d); check("R1 misc", d, 1);
    rd(4'h4, d); check("R1 cause", d, 0);

    // R2 / R5: sweep WT and action
    for (int wt = 0; wt < 16; wt++) begin
      for (int a = 0; a < 2; a++) begin
        full_reset();
        wr(4'h0, 16'((wt << 8) | 16'h0034 | (a << 3)));
        t0 = cyc;
        wait_ev(a, 400, at);
        check("R2 expiry delay", at - t0, DIV * (wt + 1));
        if (a == 0) check("R5 ext stays high on internal action", ext_rst_n, 1);
        else        check("R5 int stays low on external action", int_rst_req, 0);
        @(negedge clk);
        check("R2 event lasts one cycle", seen(a), 0);
        wait_ev(a, 400, at2);
        check("R2 period after expiry", at2 - at, DIV * (wt + 1));
      end
    end

    // R3 enable is sticky, clearing write neither stops nor reloads
    full_reset();
    wr(4'h0, 16'h0334); t0 = cyc;
    wr(4'h0, 16'h0330);
    rd(4'h0, d); check("R3 enable reads 1", (d >> 2) & 1, 1);
    wait_ev(0, 200, at); check("R3 countdown unchanged", at - t0, 16);

    // R4 valid service
    full_reset();
    wr(4'h0, 16'h0334); t0 = cyc;
    until_cyc(t0 + 6);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA); t1 = cyc;
    wait_ev(0, 200, at); check("R4 valid service reloads", at - t1, 16);
    // R4 0xAAAA alone
    full_reset();
    wr(4'h0, 16'h0334); t0 = cyc;
    wr(4'h2, 16'hAAAA);
    wait_ev(0, 200, at); check("R4 lone second word ignored", at - t0, 16);
    // R4 foreign value between
    full_reset();
    wr(4'h0, 16'h0334); t0 = cyc;
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    wait_ev(0, 200, at); check("R4 broken sequence ignored", at - t0, 16);
    // R4 reversed order
    full_reset();
    wr(4'h0, 16'h0334); t0 = cyc;
    wr(4'h2, 16'hAAAA); wr(4'h2, 16'h5555);
    wait_ev(0, 200, at); check("R4 reversed order ignored", at - t0, 16);
    // R4 repeated first word still arms
    full_reset();
    wr(4'h0, 16'h0334);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA); t1 = cyc;
    wait_ev(0, 200, at); check("R4 repeated first word reloads", at - t1, 16);
    // R4 collision: reload on the expiry edge
    full_reset();
    wr(4'h0, 16'h0334); t0 = cyc;
    wr(4'h2, 16'h5555);
    until_cyc(t0 + 14);
    wr(4'h2, 16'hAAAA); t1 = cyc;
    check("R4 collision write edge", t1 - t0, 16);
    check("R4 no timeout on collision edge", int_rst_req, 0);
    wait_ev(0, 200, at); check("R4 reload wins collision", at - t0, 32);

    // R6 software reset
    full_reset();
    wr(4'h0, 16'h0020);
    check("R6 sw reset asserts", int_rst_req, 1);
    rd(4'h0, d); check("R6 ctrl readback", d, 16'h0020);
    wr(4'h0, 16'h0030);
    check("R6 sw reset releases", int_rst_req, 0);
    // R7 external reset control
    wr(4'h0, 16'h0010);
    check("R7 ext reset asserts", ext_rst_n, 0);
    check("R7 int stays low", int_rst_req, 0);
    wr(4'h0, 16'h0030);
    check("R7 ext reset releases", ext_rst_n, 1);

    // R8 suspend freezes countdown
    full_reset();
    wr(4'h0, 16'h0335); t0 = cyc;
    until_cyc(t0 + 5); lp_mode = 1'b1;
    until_cyc(t0 + 25); lp_mode = 1'b0;
    wait_ev(0, 200, at); check("R8 suspend delays expiry", at - t0, 36);
    wr(4'h0, 16'h0334);
    rd(4'h0, d); check("R8 suspend bit stays set", d & 1, 1);
    // R8 bit clear: lp_mode ignored, and bit cannot be set later
    full_reset();
    lp_mode = 1'b1;
    wr(4'h0, 16'h0334); t0 = cyc;
    wait_ev(0, 200, at); check("R8 lp_mode ignored without suspend", at - t0, 16);
    lp_mode = 1'b0;
    wr(4'h0, 16'h0335);
    rd(4'h0, d); check("R8 suspend bit write-once", d & 1, 0);

    // R9 pre-timeout sweep
    for (int p = 1; p < 8; p++) begin
      full_reset();
      wr(4'h6, 16'(16'h8000 | p));
      wr(4'h0, 16'h0734); t0 = cyc;
      wait_ev(2, 200, at);
      check("R9 pre-timeout delay", at - t0, DIV * (8 - p));
      rd(4'h6, d); check("R9 status set", (d >> 14) & 1, 1);
      wr(4'h6, 16'(16'h8000 | p));
      check("R9 write 0 keeps status", irq, 1);
      wr(4'h6, 16'(16'hC000 | p));
      check("R9 write 1 clears irq", irq, 0);
      rd(4'h6, d); check("R9 status cleared", d, 16'h8000 | p);
    end
    // R9 enable bit gates irq
    full_reset();
    wr(4'h6, 16'h0003);
    wr(4'h0, 16'h0734); t0 = cyc;
    until_cyc(t0 + 24);
    check("R9 irq gated off", irq, 0);
    rd(4'h6, d); check("R9 status without enable", d, 16'h4003);

    // R10 timeout cause
    full_reset();
    wr(4'h0, 16'h0134);
    wait_ev(0, 200, at);
    rd(4'h4, d); check("R10 cause set", d, 2);
    sys_reset();
    rd(4'h4, d); check("R10 cause survives rst_n", d, 2);
    rd(4'h0, d); check("R10 ctrl cleared by rst_n", d, 16'h0030);
    wr(4'h0, 16'h0020);
    rd(4'h4, d); check("R10 sw reset clears cause", d, 0);
    wr(4'h0, 16'h0030);
    sys_reset();
    wr(4'h0, 16'h0134);
    wait_ev(0, 200, at);
    full_reset();
    rd(4'h4, d); check("R10 por clears cause", d, 0);

    // R11 power-down disable
    rd(4'h8, d); check("R11 reset value", d, 1);
    wr(4'h8, 16'h0001); rd(4'h8, d); check("R11 write 1 keeps", d, 1);
    wr(4'h8, 16'h0000); rd(4'h8, d); check("R11 write 0 clears", d, 0);
    wr(4'h8, 16'h0001); rd(4'h8, d); check("R11 cannot re-set", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule